// File: doc/BRIEF.md
# Multi-channel compare alarm unit

The block holds a small set of alarm channels that watch the low 32 bits of a free-running timebase supplied from outside. Software loads a channel's target word over an APB register interface. That write both stores the target and arms the channel. An armed channel fires when the timebase equals its target exactly. On firing it drops back to idle and latches a raw interrupt bit. Software can cancel a pending alarm through a write-one-to-cancel register.

Each channel's interrupt output combines three registers: a raw bit, an enable bit and a force bit. The force bits let software raise an interrupt line without any alarm firing. A lock input freezes the target, armed and raw registers against writes. The enable and force registers stay writable while the lock is high.

Each channel is a two-state machine:
- State CH_IDLE moves to CH_ARMED on a target write (transition ARM).
- State CH_ARMED stays in CH_ARMED on a target write (transition REARM).
- It goes back to CH_IDLE on a match (transition FIRE) or on a cancel write (transition CANCEL).
- Otherwise it holds in CH_ARMED (transition WAIT).

A target write has priority over a cancel write, and a cancel write has priority over a match.

Top module: `alarm_unit`

## Requirements
- R1: After reset every target reads 0, and the armed (0x20), raw (0x3C), enable (0x40), force (0x44) and status (0x48) registers all read 0. `irq` is 0.
- R2: A write to address 0x10+4*i stores pwdata as channel i's target. The target reads back at the same address. The write also sets bit i of the armed register (0x20) at the next clock edge.
- R3: When channel i is armed and `time_lo` equals its target at a clock edge, the channel clears armed bit i and sets raw bit i (0x3C) at that edge. Once disarmed, the channel does not set the raw bit again while the match persists.
- R4: Writing 1 to bit i of the armed register (0x20) disarms channel i. The raw bit is not set, and a later match on the old target does nothing. Writing 0 to a bit has no effect.
- R5: Writing 1 to bit i of the raw register (0x3C) clears that bit. Writing 0 to a bit leaves it unchanged.
- R6: The enable register (0x40) and force register (0x44) are read-write, one bit per channel. Bit i of status (0x48) and `irq[i]` both equal (raw AND enable) OR force.
- R7: If a fire and a clear write to the same raw bit happen at the same edge, the raw bit ends up set.
- R8: If a target write to channel i coincides with a match on its old target, channel i stays armed with the new target and the raw bit is not set. A later match on the new target fires normally.
- R9: While `lock` is high, writes to the target, armed and raw registers are ignored. Writes to enable and force still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, 0 for unmapped addresses |
| pready | output | 1 | APB ready, always 1 |
| time_lo | input | 32 | Low 32 bits of the external timebase |
| lock | input | 1 | Write lock for target, armed and raw registers |
| irq | output | 4 | Per-channel interrupt, (raw & enable) \| force |

## Verification
A channel stuck in the wrong state shows up one edge after the event that should have moved it. The armed register at 0x20 reads the wrong value, and the raw bit at 0x3C either appears without a match or fails to appear after one. A wrong priority between a target write, a cancel and a match leaves the raw or armed bit wrong right after the coincident edge. A fault in the combine logic shows at once on `irq` and in the status register, with no clock delay.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int OFS_TARGET = 'h10;
    localparam int OFS_ARMED  = 'h20;
    localparam int OFS_RAW    = 'h3C;
    localparam int OFS_EN     = 'h40;
    localparam int OFS_FORCE  = 'h44;
    localparam int OFS_STAT   = 'h48;

    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_ARMED = 1'b1
    } ch_state_t;
endpackage

// File: rtl/alarm_decode.sv
module alarm_decode
    import alarm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 8,
    parameter int DW     = 32
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [AW-1:0]     paddr,
    input  logic [DW-1:0]     pwdata,
    input  logic              lock,
    output logic [NUM_CH-1:0] wr_target,
    output logic [NUM_CH-1:0] cancel_mask,
    output logic [NUM_CH-1:0] clear_mask,
    output logic              wr_en,
    output logic              wr_force
);
    logic wr_cyc;
    logic open_wr;

    assign wr_cyc  = psel & penable & pwrite;
    assign open_wr = wr_cyc & ~lock;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_tgt
        assign wr_target[i] = open_wr && (paddr == AW'(OFS_TARGET + 4 * i));
    end

    assign cancel_mask = (open_wr && paddr == AW'(OFS_ARMED)) ? pwdata[NUM_CH-1:0] : '0;
    assign clear_mask  = (open_wr && paddr == AW'(OFS_RAW))   ? pwdata[NUM_CH-1:0] : '0;
    assign wr_en       = wr_cyc && (paddr == AW'(OFS_EN));
    assign wr_force    = wr_cyc && (paddr == AW'(OFS_FORCE));
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel
    import alarm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_target,
    input  logic [DW-1:0] wr_data,
    input  logic          cancel,
    input  logic [DW-1:0] time_lo,
    output logic          armed,
    output logic [DW-1:0] target,
    output logic          fire
);
    ch_state_t state, state_nx;
    logic      match;

    assign match = (target == time_lo);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         target <= '0;
        else if (wr_target) target <= wr_data;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE:  if (wr_target) state_nx = CH_ARMED;
            CH_ARMED: begin
                if (wr_target)           state_nx = CH_ARMED;
                else if (cancel || match) state_nx = CH_IDLE;
                else                      state_nx = CH_ARMED;
            end
            default:  state_nx = CH_IDLE;
        endcase
    end

    always_comb begin
        armed = (state == CH_ARMED);
        fire  = (state == CH_ARMED) && match && !wr_target && !cancel;
    end

    AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_target |=> armed); // R2
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_target |=> target == $past(wr_data)); // R2
    AST_MATCH_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && target == time_lo && !wr_target) |=> !armed); // R3
    AST_CANCEL_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel && !wr_target) |-> !fire); // R4
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] fire,
    input  logic [NUM_CH-1:0] clear_mask,
    input  logic              wr_en,
    input  logic              wr_force,
    input  logic [NUM_CH-1:0] wdata,
    output logic [NUM_CH-1:0] raw,
    output logic [NUM_CH-1:0] enable,
    output logic [NUM_CH-1:0] force_bits,
    output logic [NUM_CH-1:0] status
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw        <= '0;
            enable     <= '0;
            force_bits <= '0;
        end else begin
            raw <= (raw & ~clear_mask) | fire;
            if (wr_en)    enable     <= wdata;
            if (wr_force) force_bits <= wdata;
        end
    end

    assign status = (raw & enable) | force_bits;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_FIRE_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> raw[i]); // R7
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clear_mask[i] && !fire[i]) |=> !raw[i]); // R5
        AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!clear_mask[i] && raw[i]) |=> raw[i]); // R5
    end
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
    import alarm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 8,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [AW-1:0]     paddr,
    input  logic [DW-1:0]     pwdata,
    output logic [DW-1:0]     prdata,
    output logic              pready,
    input  logic [DW-1:0]     time_lo,
    input  logic              lock,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0] wr_target, cancel_mask, clear_mask;
    logic              wr_en, wr_force;
    logic [NUM_CH-1:0] armed, fire, raw, enable, force_bits, status;
    logic [DW-1:0]     target [NUM_CH];
    logic [DW-1:0]     rd_mux;

    alarm_decode #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_dec (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .lock(lock), .wr_target(wr_target),
        .cancel_mask(cancel_mask), .clear_mask(clear_mask),
        .wr_en(wr_en), .wr_force(wr_force)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        alarm_channel #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n), .wr_target(wr_target[i]),
            .wr_data(pwdata), .cancel(cancel_mask[i]), .time_lo(time_lo),
            .armed(armed[i]), .target(target[i]), .fire(fire[i])
        );
    end

    alarm_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk(clk), .rst_n(rst_n), .fire(fire), .clear_mask(clear_mask),
        .wr_en(wr_en), .wr_force(wr_force), .wdata(pwdata[NUM_CH-1:0]),
        .raw(raw), .enable(enable), .force_bits(force_bits), .status(status)
    );

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (paddr == AW'(OFS_TARGET + 4 * i)) rd_mux = target[i];
        unique case (paddr)
            AW'(OFS_ARMED): rd_mux = DW'(armed);
            AW'(OFS_RAW):   rd_mux = DW'(raw);
            AW'(OFS_EN):    rd_mux = DW'(enable);
            AW'(OFS_FORCE): rd_mux = DW'(force_bits);
            AW'(OFS_STAT):  rd_mux = DW'(status);
            default: ;
        endcase
    end

    assign prdata = (psel && !pwrite) ? rd_mux : '0;
    assign pready = 1'b1;
    assign irq    = status;

    AST_LOCK_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> !$rose(armed[0])); // R9
    AST_LOCK_KEEPS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && raw[0]) |=> raw[0]); // R9
    AST_IRQ_MATCHES_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((raw & enable) | force_bits)); // R6
endmodule

// File: tb/sim_alarm_unit.sv
module sim_alarm_unit;
    localparam logic [31:0] IDLE_T = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [31:0] time_lo = IDLE_T;
    logic        lock = 1'b0;
    logic [3:0]  irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    alarm_unit u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .time_lo(time_lo), .lock(lock), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_wr(logic [7:0] a, logic [31:0] d,
                          bit hit = 0, logic [31:0] tv = '0);
        @(negedge clk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk);
        penable = 1;
        if (hit) time_lo = tv;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        time_lo = IDLE_T;
    endtask

    task automatic apb_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk);
        penable = 1;
        #1 d = prdata;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
        logic [31:0] v;
        apb_rd(a, v);
        check(req, v, exp);
    endtask

    task automatic hold_time(logic [31:0] tv, int n);
        @(negedge clk);
        time_lo = tv;
        repeat (n) @(negedge clk);
        time_lo = IDLE_T;
    endtask

    task automatic t_reset();
        rd_check("R1 target0", 8'h10, 0);
        rd_check("R1 target3", 8'h1C, 0);
        rd_check("R1 armed", 8'h20, 0);
        rd_check("R1 raw", 8'h3C, 0);
        rd_check("R1 enable", 8'h40, 0);
        rd_check("R1 force", 8'h44, 0);
        rd_check("R1 status", 8'h48, 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_arm_fire();
        apb_wr(8'h10, 32'h100);
        rd_check("R2 target0 readback", 8'h10, 32'h100);
        rd_check("R2 armed bit0", 8'h20, 32'h1);
        rd_check("R3 no fire before match", 8'h3C, 0);
        hold_time(32'h100, 3);
        rd_check("R3 disarmed on match", 8'h20, 0);
        rd_check("R3 raw set", 8'h3C, 32'h1);
        check("R6 irq masked", 32'(irq), 0);
        apb_wr(8'h40, 32'h1);
        rd_check("R6 enable readback", 8'h40, 32'h1);
        check("R6 irq enabled", 32'(irq), 32'h1);
        rd_check("R6 status", 8'h48, 32'h1);
        apb_wr(8'h3C, 32'h0);
        rd_check("R5 write zero keeps raw", 8'h3C, 32'h1);
        apb_wr(8'h3C, 32'h1, 1, 32'h100);
        rd_check("R5 clear, R3 no refire", 8'h3C, 0);
        check("R6 irq after clear", 32'(irq), 0);
    endtask

    task automatic t_cancel();
        apb_wr(8'h14, 32'h150);
        rd_check("R4 armed bit1", 8'h20, 32'h2);
        apb_wr(8'h20, 32'h0);
        rd_check("R4 zero write no effect", 8'h20, 32'h2);
        apb_wr(8'h20, 32'h2);
        rd_check("R4 cancelled", 8'h20, 0);
        hold_time(32'h150, 2);
        rd_check("R4 no raw after cancel", 8'h3C, 0);
    endtask

    task automatic t_force();
        apb_wr(8'h44, 32'h4);
        rd_check("R6 force readback", 8'h44, 32'h4);
        check("R6 irq forced", 32'(irq), 32'h4);
        rd_check("R6 status forced", 8'h48, 32'h4);
        apb_wr(8'h44, 32'h0);
        check("R6 force released", 32'(irq), 0);
    endtask

    task automatic t_fire_vs_clear();
        apb_wr(8'h1C, 32'h300);
        apb_wr(8'h3C, 32'h8, 1, 32'h300);
        rd_check("R7 fire beats clear", 8'h3C, 32'h8);
        rd_check("R7 disarmed", 8'h20, 0);
    endtask

    task automatic t_rearm_on_match();
        apb_wr(8'h18, 32'h200);
        apb_wr(8'h18, 32'h280, 1, 32'h200);
        rd_check("R8 still armed", 8'h20, 32'h4);
        rd_check("R8 stale match ignored", 8'h3C, 32'h8);
        rd_check("R8 new target", 8'h18, 32'h280);
        hold_time(32'h280, 1);
        rd_check("R8 fires on new target", 8'h3C, 32'hC);
        rd_check("R8 disarmed after fire", 8'h20, 0);
    endtask

    task automatic t_lock();
        apb_wr(8'h14, 32'h1234);
        @(negedge clk);
        lock = 1;
        apb_wr(8'h3C, 32'hF);
        rd_check("R9 raw clear ignored", 8'h3C, 32'hC);
        apb_wr(8'h20, 32'h2);
        rd_check("R9 cancel ignored", 8'h20, 32'h2);
        apb_wr(8'h10, 32'h555);
        rd_check("R9 target write ignored", 8'h10, 32'h100);
        rd_check("R9 no arm under lock", 8'h20, 32'h2);
        apb_wr(8'h40, 32'hF);
        rd_check("R9 enable writable", 8'h40, 32'hF);
        check("R9 irq from raw", 32'(irq), 32'hC);
        apb_wr(8'h44, 32'h1);
        check("R9 force writable", 32'(irq), 32'hD);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_arm_fire();
        t_cancel();
        t_force();
        t_fire_vs_clear();
        t_rearm_on_match();
        t_lock();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule